// File: doc/BRIEF.md
# Interrupt Number Dispatch Controller

The controller watches 64 level-sensitive interrupt lines and turns them into a single outstanding interrupt request. Lines 0 to 31 belong to expansion-bus slots and share one mapping register per group of four lines. Lines 32 to 63 belong to on-board devices, and each has its own mapping register. A source can raise a request only while the enable bit of its mapping register is set.

The controller keeps exactly one request register. It holds either a source number from 0 to 63 or an idle code. The held request is presented as a one-hot bit on `req_vec` until software withdraws it. Software withdraws it either by writing the matching clear register or by disabling the source's mapping register.

Software reaches the mapping and clear registers through a simple bus with a write strobe, an address and write data. Reads are combinational from the address.

Top module: `irq_dispatch`

## Requirements
- R1: After reset no request is shown (`req_vec` is zero). Every enable bit reads 0. PCI mapping register i reads 0x7C0 | (i<<2). On-board mapping register k reads 0x7E0 + k. A reset in the middle of a run clears the enable bits in the same way.
- R2: PCI mapping register i sits at byte address 0x0C00 + 8*i, for i from 0 to 7. On-board mapping register k sits at 0x1000 + 8*k, for k from 0 to 31. A write stores only data bit 31, the enable bit. Bits 30:0 ignore writes. A read returns all 32 bits.
- R3: An address outside the mapping registers reads as zero, and writing to such an address changes nothing.
- R4: Source n below 32 is gated by PCI mapping register n/4. Source 32+k is gated by on-board mapping register k. A source whose register is disabled never becomes the request.
- R5: When no request is outstanding, the lowest-numbered pending source that is enabled becomes the request at the next clock edge. Every PCI source therefore ranks above every on-board source.
- R6: An outstanding request is held after its line drops. A newly active on-board source cannot displace it.
- R7: A PCI line that rises while its mapping is enabled replaces an outstanding request at the next edge. If several PCI lines rise together, the lowest-numbered one wins.
- R8: A mapping write with bit 31 clear withdraws the outstanding request when that register gates the outstanding source. A mapping write to any other register leaves the request in place.
- R9: A write to the PCI clear space 0x1400 + 32*g (g = address bits 7:5) withdraws the request when it is a PCI source with number/4 equal to g. Such a write never withdraws an on-board request.
- R10: A write to the on-board clear space 0x1800 + 8*k (k = address bits 7:3) withdraws the request only when the request is exactly source 32+k.
- R11: `req_vec` has at most one bit set, and the set bit is the number of the outstanding source.
- R12: The cycle after a withdrawal always shows no request. Selection of the next source resumes on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Level interrupt lines; 0-31 expansion slots, 32-63 on-board devices |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| req_vec | output | 64 | One-hot outstanding request |

## Verification
The hardest state to reach from the ports is a held request that meets a competing event in the same cycle. One case is a PCI line rising while another source is outstanding. Another is a pending source whose group is disabled at the moment the request is withdrawn, so that the next selection must skip it. The directed sequence sets this up deliberately. It enables a single PCI group, leaves lines of disabled groups active, and raises an on-board line while a PCI request is held. It then enables a second group and raises one of its lines to force a replacement. Finally it disables the groups one at a time, checking that the on-board source is picked only after the idle cycle.

// File: rtl/irq_dispatch_pkg.sv
`timescale 1ns/1ps
package irq_dispatch_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    // Register pages (upper address bits select the space)
    localparam logic [ADDR_W-1:0] PCI_MAP_BASE  = 16'h0C00;
    localparam logic [ADDR_W-1:0] OBIO_MAP_BASE = 16'h1000;
    localparam logic [ADDR_W-1:0] PCI_CLR_BASE  = 16'h1400;
    localparam logic [ADDR_W-1:0] OBIO_CLR_BASE = 16'h1800;

    localparam logic [11:0] PCI_LOW_FILL  = 12'h7C0;
    localparam logic [11:0] OBIO_LOW_FILL = 12'h7E0;

    typedef enum logic [2:0] {
        EV_IDLE,
        EV_PCI_MAP,
        EV_OBIO_MAP,
        EV_PCI_CLR,
        EV_OBIO_CLR
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e   kind;
        logic [4:0] idx;
        logic       en;
    } wr_ev_t;

    function automatic logic [DATA_W-2:0] pci_low(input logic [4:0] i);
        return (DATA_W-1)'(PCI_LOW_FILL) | (DATA_W-1)'({i, 2'b00});
    endfunction

    function automatic logic [DATA_W-2:0] obio_low(input logic [4:0] k);
        return (DATA_W-1)'(OBIO_LOW_FILL) + (DATA_W-1)'(k);
    endfunction

endpackage

// File: rtl/irq_dispatch_pick.sv
`timescale 1ns/1ps
module irq_dispatch_pick #(
    parameter int N  = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    output logic          hit,
    output logic [IW-1:0] idx
);

    always_comb begin
        hit = |cand;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_dispatch_regs.sv
`timescale 1ns/1ps
module irq_dispatch_regs
    import irq_dispatch_pkg::*;
#(
    parameter int N_PMAP = 8,
    parameter int N_OBIO = 32,
    localparam int PIW   = $clog2(N_PMAP),
    localparam int OIW   = $clog2(N_OBIO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_PMAP-1:0] pci_en_q,
    output logic [N_PMAP-1:0] pci_en_nx,
    output logic [N_OBIO-1:0] obio_en_q,
    output logic [N_OBIO-1:0] obio_en_nx,
    output wr_ev_t            wr_ev
);

    typedef struct packed {
        logic [N_PMAP-1:0] pci_en;
        logic [N_OBIO-1:0] obio_en;
    } regs_t;

    regs_t    s_d, s_q;
    wr_kind_e kind;
    logic [4:0] idx;
    logic [DATA_W-2:0] unused_wdata_low;

    assign unused_wdata_low = bus_wdata[DATA_W-2:0];

    // Address decode
    always_comb begin
        kind = EV_IDLE;
        idx  = '0;
        if (bus_addr[ADDR_W-1:6] == PCI_MAP_BASE[ADDR_W-1:6]
            && 32'(bus_addr[5:3]) < N_PMAP) begin
            kind = EV_PCI_MAP;
            idx  = 5'(bus_addr[5:3]);
        end else if (bus_addr[ADDR_W-1:8] == OBIO_MAP_BASE[ADDR_W-1:8]
                     && 32'(bus_addr[7:3]) < N_OBIO) begin
            kind = EV_OBIO_MAP;
            idx  = bus_addr[7:3];
        end else if (bus_addr[ADDR_W-1:8] == PCI_CLR_BASE[ADDR_W-1:8]
                     && 32'(bus_addr[7:5]) < N_PMAP) begin
            kind = EV_PCI_CLR;
            idx  = 5'(bus_addr[7:5]);
        end else if (bus_addr[ADDR_W-1:8] == OBIO_CLR_BASE[ADDR_W-1:8]
                     && 32'(bus_addr[7:3]) < N_OBIO) begin
            kind = EV_OBIO_CLR;
            idx  = bus_addr[7:3];
        end
    end

    // Read mux
    always_comb begin
        case (kind)
            EV_PCI_MAP:  bus_rdata = {s_q.pci_en[idx[PIW-1:0]], pci_low(idx)};
            EV_OBIO_MAP: bus_rdata = {s_q.obio_en[idx[OIW-1:0]], obio_low(idx)};
            default:     bus_rdata = '0;
        endcase
    end

    // Next state
    always_comb begin
        s_d = s_q;
        if (bus_wr) begin
            if (kind == EV_PCI_MAP) begin
                s_d.pci_en[idx[PIW-1:0]] = bus_wdata[DATA_W-1];
            end else if (kind == EV_OBIO_MAP) begin
                s_d.obio_en[idx[OIW-1:0]] = bus_wdata[DATA_W-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pci_en_q   = s_q.pci_en;
    assign obio_en_q  = s_q.obio_en;
    assign pci_en_nx  = s_d.pci_en;
    assign obio_en_nx = s_d.obio_en;
    assign wr_ev      = '{kind: (bus_wr ? kind : EV_IDLE), idx: idx, en: bus_wdata[DATA_W-1]};

    // R2
    pci_map_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev.kind == EV_PCI_MAP) |=> (pci_en_q[$past(wr_ev.idx[PIW-1:0])] == $past(wr_ev.en)));

    // R2
    obio_map_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev.kind == EV_OBIO_MAP) |=> (obio_en_q[$past(wr_ev.idx[OIW-1:0])] == $past(wr_ev.en)));

endmodule

// File: rtl/irq_dispatch.sv
`timescale 1ns/1ps
module irq_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int N_PCI   = 32,
    parameter int N_OBIO  = 32,
    parameter int PCI_GRP = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_PCI+N_OBIO-1:0] irq_in,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [N_PCI+N_OBIO-1:0] req_vec
);

    localparam int N_SRC  = N_PCI + N_OBIO;
    localparam int N_PMAP = N_PCI / PCI_GRP;
    localparam int IDX_W  = $clog2(N_SRC);
    localparam int SRC_W  = $clog2(N_SRC + 1);
    localparam int PIDX_W = $clog2(N_PCI);
    localparam int GRP_W  = $clog2(PCI_GRP);
    localparam int PMW    = $clog2(N_PMAP);
    localparam int OIW    = $clog2(N_OBIO);
    localparam logic [SRC_W-1:0] NONE = SRC_W'(N_SRC);

    typedef struct packed {
        logic [SRC_W-1:0] req;
        logic [N_PCI-1:0] irq_prev;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [N_PMAP-1:0] pci_en_q, pci_en_nx;
    logic [N_OBIO-1:0] obio_en_q, obio_en_nx;
    wr_ev_t            wr_ev;

    logic [N_SRC-1:0]  src_en_q, src_en_nx, cand;
    logic [N_PCI-1:0]  rise;
    logic              all_hit, rise_hit;
    logic [IDX_W-1:0]  all_idx;
    logic [PIDX_W-1:0] rise_idx;

    logic              req_valid, req_is_pci, req_is_obio;
    logic [IDX_W-1:0]  req_num;
    logic [PMW-1:0]    req_grp;
    logic              grp_match, obio_match, clear_hit;

    irq_dispatch_regs #(
        .N_PMAP (N_PMAP),
        .N_OBIO (N_OBIO)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pci_en_q   (pci_en_q),
        .pci_en_nx  (pci_en_nx),
        .obio_en_q  (obio_en_q),
        .obio_en_nx (obio_en_nx),
        .wr_ev      (wr_ev)
    );

    // Per-source enable from the mapping registers
    for (genvar n = 0; n < N_SRC; n++) begin : g_src
        if (n < N_PCI) begin : g_pci
            assign src_en_q[n]  = pci_en_q[n / PCI_GRP];
            assign src_en_nx[n] = pci_en_nx[n / PCI_GRP];
        end else begin : g_obio
            assign src_en_q[n]  = obio_en_q[n - N_PCI];
            assign src_en_nx[n] = obio_en_nx[n - N_PCI];
        end
        assign req_vec[n] = req_valid && (req_num == IDX_W'(n));
    end

    assign cand = irq_in & src_en_nx;
    assign rise = irq_in[N_PCI-1:0] & ~s_q.irq_prev & src_en_nx[N_PCI-1:0];

    irq_dispatch_pick #(.N(N_SRC)) u_pick_all (
        .cand (cand),
        .hit  (all_hit),
        .idx  (all_idx)
    );

    irq_dispatch_pick #(.N(N_PCI)) u_pick_rise (
        .cand (rise),
        .hit  (rise_hit),
        .idx  (rise_idx)
    );

    // Outstanding-request decode
    assign req_valid   = (s_q.req != NONE);
    assign req_num     = s_q.req[IDX_W-1:0];
    assign req_is_pci  = req_valid && (req_num < IDX_W'(N_PCI));
    assign req_is_obio = req_valid && !req_is_pci;
    assign req_grp     = req_num[PIDX_W-1:GRP_W];
    assign grp_match   = req_is_pci && (req_grp == wr_ev.idx[PMW-1:0]);
    assign obio_match  = req_is_obio
                         && ((req_num - IDX_W'(N_PCI)) == IDX_W'(wr_ev.idx));

    always_comb begin
        case (wr_ev.kind)
            EV_PCI_MAP:  clear_hit = !wr_ev.en && grp_match;
            EV_OBIO_MAP: clear_hit = !wr_ev.en && obio_match;
            EV_PCI_CLR:  clear_hit = grp_match;
            EV_OBIO_CLR: clear_hit = obio_match;
            default:     clear_hit = 1'b0;
        endcase
    end

    always_comb begin
        s_d          = s_q;
        s_d.irq_prev = irq_in[N_PCI-1:0];
        if (clear_hit) begin
            s_d.req = NONE;
        end else if (!req_valid) begin
            if (all_hit) begin
                s_d.req = SRC_W'(all_idx);
            end
        end else if (rise_hit) begin
            s_d.req = SRC_W'(rise_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.req      <= NONE;
            s_q.irq_prev <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    logic [N_PCI-1:0] clr_grp_mask;
    assign clr_grp_mask = N_PCI'({PCI_GRP{1'b1}}) << (int'(wr_ev.idx[PMW-1:0]) * PCI_GRP);

    // R11
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_vec));

    // R4
    req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> src_en_q[req_num]);

    // R5
    lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |->
            (($past(cand) & ((N_SRC'(1) << req_num) - N_SRC'(1))) == '0));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && wr_ev.kind == EV_IDLE && !rise_hit) |=> $stable(req_vec));

    // R9
    pci_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev.kind == EV_PCI_CLR && |(req_vec[N_PCI-1:0] & clr_grp_mask))
            |=> (req_vec == '0));

    // R10
    obio_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev.kind == EV_OBIO_CLR && req_vec[N_PCI + int'(wr_ev.idx[OIW-1:0])])
            |=> (req_vec == '0));

endmodule

// File: tb/irq_dispatch_test.sv
`timescale 1ns/1ps
module irq_dispatch_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] irq_in;
    logic        bus_wr;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [63:0] req_vec;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    irq_dispatch uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .req_vec   (req_vec)
    );

    typedef struct packed {
        logic [63:0] pat;
        logic [6:0]  exp;   // 64 means no request
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0000_0001, 7'd0},
        '{64'h0000_0000_8000_0000, 7'd31},
        '{64'h0000_0001_0000_0000, 7'd32},
        '{64'h8000_0000_0000_0000, 7'd63},
        '{64'hF000_0000_0000_0100, 7'd8},
        '{64'h0000_0010_0000_0000, 7'd36},
        '{64'h0000_0000_0000_0000, 7'd64},
        '{64'hFFFF_FFFF_FFFF_FFFF, 7'd0},
        '{64'h0000_0400_0000_4000, 7'd14}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic report(input logic ok, input string tag,
                          input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic check_rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        report(bus_rdata == exp, tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic check_req(input int n, input string tag);
        logic [63:0] exp;
        exp = (n < 64) ? (64'd1 << n) : 64'd0;
        report(req_vec == exp, tag, req_vec, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        irq_in    = '0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state
        check_req(64, "R1 no request after reset");
        check_rd(16'h0C18, 32'h0000_07CC, "R1 pci map 3 reset value");
        check_rd(16'h1028, 32'h0000_07E5, "R1 on-board map 5 reset value");
        check_rd(16'h10F8, 32'h0000_07FF, "R1 on-board map 31 reset value");

        // R2: only the enable bit is writable
        bus_write(16'h0C18, 32'hFFFF_FFFF);
        check_rd(16'h0C18, 32'h8000_07CC, "R2 pci map enable set, low field fixed");
        bus_write(16'h0C18, 32'h0000_0000);
        check_rd(16'h0C18, 32'h0000_07CC, "R2 pci map enable cleared");
        bus_write(16'h1028, 32'h8000_0000);
        check_rd(16'h1028, 32'h8000_07E5, "R2 on-board map enable set");
        bus_write(16'h1028, 32'h0000_0000);

        // R3: unmapped space
        bus_write(16'h2000, 32'hFFFF_FFFF);
        check_rd(16'h2000, 32'h0, "R3 unmapped reads zero");
        check_rd(16'h0C40, 32'h0, "R3 past last pci map reads zero");
        check_rd(16'h1400, 32'h0, "R3 clear space reads zero");

        // Vector table: all mappings enabled, R5 / R12
        for (int i = 0; i < 8; i++) bus_write(16'h0C00 + 16'(i * 8), 32'h8000_0000);
        for (int k = 0; k < 32; k++) bus_write(16'h1000 + 16'(k * 8), 32'h8000_0000);
        for (int v = 0; v < NV; v++) begin
            irq_in = VECS[v].pat;
            tick();
            check_req(int'(VECS[v].exp), $sformatf("R5 vector %0d lowest pending", v));
            irq_in = '0;
            if (VECS[v].exp < 32) begin
                bus_write(16'h1400 + 16'(int'(VECS[v].exp) / 4 * 32), 32'h0);
                check_req(64, $sformatf("R9 vector %0d group clear", v));
            end else if (VECS[v].exp < 64) begin
                bus_write(16'h1800 + 16'((int'(VECS[v].exp) - 32) * 8), 32'h0);
                check_req(64, $sformatf("R10 vector %0d exact clear", v));
            end else begin
                tick();
                check_req(64, $sformatf("R5 vector %0d nothing pending", v));
            end
            tick();
            check_req(64, $sformatf("R12 vector %0d idle after clear", v));
        end
        for (int i = 0; i < 8; i++) bus_write(16'h0C00 + 16'(i * 8), 32'h0);
        for (int k = 0; k < 32; k++) bus_write(16'h1000 + 16'(k * 8), 32'h0);

        // R4: gating by mapping register
        bus_write(16'h0C08, 32'h8000_0000);              // group of lines 4..7
        irq_in = (64'd1 << 0) | (64'd1 << 5) | (64'd1 << 40);
        tick();
        check_req(5, "R4 disabled lines 0 and 40 skipped");

        // R6: hold while unacknowledged
        irq_in = (64'd1 << 0) | (64'd1 << 40);
        tick();
        check_req(5, "R6 held after line drops");
        bus_write(16'h1008, 32'h8000_0000);              // on-board 33 enabled
        check_req(5, "R6 held across on-board map write");
        irq_in = (64'd1 << 0) | (64'd1 << 33) | (64'd1 << 40);
        tick();
        check_req(5, "R6 on-board source does not displace");

        // R7: rising PCI line overrides
        bus_write(16'h0C00, 32'h8000_0000);              // group of lines 0..3
        check_req(5, "R7 already-high line 0 is not a rise");
        irq_in = irq_in | (64'd1 << 2);
        tick();
        check_req(2, "R7 rising line 2 replaces request");

        // R8: disable of mapping register
        bus_write(16'h0C08, 32'h0);
        check_req(2, "R8 disabling other group has no effect");
        bus_write(16'h0C00, 32'h0);
        check_req(64, "R8 disabling own group withdraws");
        tick();
        check_req(33, "R12 selection resumes with on-board 33");

        // R10: exact match for on-board clear
        irq_in = '0;
        bus_write(16'h1810, 32'h0);
        check_req(33, "R10 clear of source 34 ignored");
        bus_write(16'h1808, 32'h0);
        check_req(64, "R10 clear of source 33 withdraws");

        // R9: group match for PCI clear
        bus_write(16'h0C10, 32'h8000_0000);              // lines 8..11
        irq_in = 64'd1 << 10;
        tick();
        check_req(10, "R9 setup line 10");
        irq_in = '0;
        bus_write(16'h1420, 32'h0);
        check_req(10, "R9 clear of group 1 ignored");
        bus_write(16'h1440, 32'h0);
        check_req(64, "R9 clear of group 2 withdraws");
        irq_in = 64'd1 << 33;
        tick();
        tick();
        check_req(33, "R9 setup on-board 33");
        irq_in = '0;
        bus_write(16'h1400, 32'h0);
        check_req(33, "R9 PCI clear ignores on-board request");
        bus_write(16'h1808, 32'h0);
        check_req(64, "R10 on-board clear after PCI clear attempt");

        // R8: on-board map disable withdraws own request
        irq_in = 64'd1 << 33;
        tick();
        check_req(33, "R8 setup on-board 33");
        irq_in = '0;
        bus_write(16'h1010, 32'h0);
        check_req(33, "R8 disabling on-board map 2 has no effect");
        bus_write(16'h1008, 32'h0);
        check_req(64, "R8 disabling on-board map 1 withdraws");

        // R1: reset in mid-run
        bus_write(16'h0C10, 32'h8000_0000);
        irq_in = 64'd1 << 9;
        tick();
        check_req(9, "R1 setup before second reset");
        irq_in = '0;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        check_req(64, "R1 request cleared by reset");
        check_rd(16'h0C10, 32'h0000_07C8, "R1 enable cleared, low field kept");
        tick();
        check_req(64, "R1 nothing selected after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule